// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit resolves the operand of one instruction from its addressing mode. A caller presents a 4-bit mode code, an address field, a register index and the current program counter, and pulses `start`. The unit reads the selected entry of an external 8-entry register file, issues zero, one or two reads to a single-port data memory whose data returns one cycle after the read request, and then reports the effective address and the fetched operand together with a one-cycle `done` pulse.

Two auto-indexing modes step the selected register by one, either before it joins the address sum (pre-increment) or after the address has been used (post-increment). The new register value leaves through a write port in the same cycle as `done`. Instruction decoding and arithmetic on the operand are handled elsewhere. Addresses and data are 16 bits wide, and every address sum wraps modulo 2^16.

Top module: `ea_unit`

## Requirements
- R1: Mode 0 (immediate) returns the address field as `operand` and 0 as `ea`, and issues no memory read.
- R2: Mode 1 (direct) uses the address field as `ea` and reads the operand from it with exactly one memory read.
- R3: Mode 2 (indirect) makes two memory reads. The first, at the address field, returns `ea`. The second, at that returned word, returns `operand`.
- R4: Mode 3 (register) returns the selected register as `operand` and 0 as `ea`, with no memory read. Mode 4 (register indirect) uses the selected register as `ea` and makes one memory read there.
- R5: Mode 5 (displacement) forms `ea` as address field plus selected register. Mode 6 (relative) forms `ea` as address field plus `pc`. Both wrap modulo 2^16 and make one memory read at `ea`.
- R6: Mode 7 (pre-increment) forms `ea` as field + register + 1. Mode 8 (post-increment) forms `ea` as field + register. Both read once at `ea` and write register + 1 (wrapping) back to the selected register, with `rf_we` high only in the `done` cycle.
- R7: Codes 9 to 15 raise `illegal` together with `done`, return 0 on `ea` and `operand`, and make no memory read or register write.
- R8: `done` is high for exactly one cycle. It rises 1 + 2n clock edges after the edge that accepts `start`, where n is the number of memory reads for the mode. Each read request lasts one cycle.
- R9: While an operation is in progress, `start` is ignored: results and the count of `done` pulses are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 4 | Addressing mode code |
| addr_field | input | 16 | Address field of the instruction |
| reg_idx | input | 3 | Register selector |
| pc | input | 16 | Current program counter |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register write-back strobe |
| rf_waddr | output | 3 | Register write-back index |
| rf_wdata | output | 16 | Register write-back value |
| mem_re | output | 1 | Data memory read request |
| mem_addr | output | 16 | Data memory read address |
| mem_rdata | input | 16 | Memory data, valid one cycle after the request |
| done | output | 1 | Result valid, one-cycle pulse |
| illegal | output | 1 | Unknown mode code, high with done |
| ea | output | 16 | Effective address |
| operand | output | 16 | Resolved operand |

## Verification
The bench builds the unit with its defaults, a 16-bit word and eight registers, so every address sum can be driven across the 0xFFFF boundary. Register values of 0xFFFF and 0xFFF0 bring the pre-increment and displacement wrap within reach. A program counter near the top of the space exercises the relative wrap. The bench memory returns a word computed from the address, so an indirect chain ends at a distinct, predictable value.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_DIR  = 4'd1,
    M_IND  = 4'd2,
    M_REG  = 4'd3,
    M_RIND = 4'd4,
    M_DISP = 4'd5,
    M_REL  = 4'd6,
    M_PRE  = 4'd7,
    M_POST = 4'd8
  } mode_e;

  typedef struct packed {
    logic       bad;
    logic [1:0] reads;
    logic       reg_operand;
    logic       autoinc;
    logic       pre_inc;
    logic       pc_base;
    logic       reg_base;
    logic       use_field;
  } mode_info_t;
endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
(
  input  logic [3:0] mode_code,
  output mode_info_t info
);
  always_comb begin
    info = '0;
    case (mode_code)
      M_IMM:  info.reads = 2'd0;
      M_DIR:  begin info.reads = 2'd1; info.use_field = 1'b1; end
      M_IND:  begin info.reads = 2'd2; info.use_field = 1'b1; end
      M_REG:  begin info.reads = 2'd0; info.reg_operand = 1'b1; end
      M_RIND: begin info.reads = 2'd1; info.reg_base = 1'b1; end
      M_DISP: begin info.reads = 2'd1; info.reg_base = 1'b1; info.use_field = 1'b1; end
      M_REL:  begin info.reads = 2'd1; info.pc_base = 1'b1; info.use_field = 1'b1; end
      M_PRE:  begin
        info.reads = 2'd1; info.reg_base = 1'b1; info.use_field = 1'b1;
        info.autoinc = 1'b1; info.pre_inc = 1'b1;
      end
      M_POST: begin
        info.reads = 2'd1; info.reg_base = 1'b1; info.use_field = 1'b1;
        info.autoinc = 1'b1;
      end
      default: info.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_wrap_add.sv
module ea_wrap_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s
);
  assign s = x + y + {{(W-1){1'b0}}, cin};
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  mode_info_t   info,
  input  logic [W-1:0] field,
  input  logic [W-1:0] regv,
  input  logic [W-1:0] pcv,
  output logic [W-1:0] ea_sum,
  output logic [W-1:0] reg_next
);
  logic [W-1:0] base_v;
  logic [W-1:0] disp_v;

  always_comb begin
    if (info.pc_base)       base_v = pcv;
    else if (info.reg_base) base_v = regv;
    else                    base_v = '0;
    disp_v = info.use_field ? field : '0;
  end

  ea_wrap_add #(.W(W)) u_sum (
    .x(base_v), .y(disp_v), .cin(info.pre_inc), .s(ea_sum)
  );

  ea_wrap_add #(.W(W)) u_inc (
    .x(regv), .y('0), .cin(1'b1), .s(reg_next)
  );
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int W    = 16,
  parameter int REGS = 8,
  localparam int IW  = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [W-1:0]  addr_field,
  input  logic [IW-1:0] reg_idx,
  input  logic [W-1:0]  pc,
  output logic [IW-1:0] rf_raddr,
  input  logic [W-1:0]  rf_rdata,
  output logic          rf_we,
  output logic [IW-1:0] rf_waddr,
  output logic [W-1:0]  rf_wdata,
  output logic          mem_re,
  output logic [W-1:0]  mem_addr,
  input  logic [W-1:0]  mem_rdata,
  output logic          done,
  output logic          illegal,
  output logic [W-1:0]  ea,
  output logic [W-1:0]  operand
);
  typedef enum logic [1:0] {S_IDLE, S_CALC, S_ISSUE, S_DATA} state_e;

  state_e        state;
  logic [3:0]    mode_q;
  logic [W-1:0]  field_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  pc_q;
  logic          second_q;
  logic          wb_pend;
  logic [W-1:0]  wb_val;
  mode_info_t    info;
  logic [W-1:0]  ea_sum;
  logic [W-1:0]  reg_next;

  ea_mode_dec u_dec (.mode_code(mode_q), .info(info));

  ea_addr_gen #(.W(W)) u_gen (
    .info(info), .field(field_q), .regv(rf_rdata), .pcv(pc_q),
    .ea_sum(ea_sum), .reg_next(reg_next)
  );

  assign rf_raddr = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      mode_q   <= '0;
      field_q  <= '0;
      idx_q    <= '0;
      pc_q     <= '0;
      second_q <= 1'b0;
      wb_pend  <= 1'b0;
      wb_val   <= '0;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      mem_re   <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      ea       <= '0;
      operand  <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      rf_we   <= 1'b0;
      mem_re  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            mode_q  <= mode;
            field_q <= addr_field;
            idx_q   <= reg_idx;
            pc_q    <= pc;
            state   <= S_CALC;
          end
        end
        S_CALC: begin
          if (info.bad) begin
            done    <= 1'b1;
            illegal <= 1'b1;
            ea      <= '0;
            operand <= '0;
            state   <= S_IDLE;
          end else if (info.reads == 2'd0) begin
            done    <= 1'b1;
            ea      <= '0;
            operand <= info.reg_operand ? rf_rdata : field_q;
            state   <= S_IDLE;
          end else begin
            ea       <= ea_sum;
            mem_re   <= 1'b1;
            mem_addr <= ea_sum;
            second_q <= (info.reads == 2'd2);
            wb_pend  <= info.autoinc;
            wb_val   <= reg_next;
            state    <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_DATA;
        S_DATA: begin
          if (second_q) begin
            second_q <= 1'b0;
            ea       <= mem_rdata;
            mem_re   <= 1'b1;
            mem_addr <= mem_rdata;
            state    <= S_ISSUE;
          end else begin
            operand  <= mem_rdata;
            done     <= 1'b1;
            rf_we    <= wb_pend;
            rf_waddr <= idx_q;
            rf_wdata <= wb_val;
            wb_pend  <= 1'b0;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
  input logic clk,
  input logic rst,
  input logic done,
  input logic illegal,
  input logic mem_re,
  input logic rf_we
);
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_read_single_r8: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);

  p_read_not_done_r8: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> !done);

  p_bad_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (done && !rf_we && !mem_re));

  p_wb_with_done_r6: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> done);
endmodule

bind ea_unit ea_unit_chk u_chk (
  .clk(clk), .rst(rst), .done(done), .illegal(illegal),
  .mem_re(mem_re), .rf_we(rf_we)
);

// File: tb/ea_unit_test.sv
module ea_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] addr_field = '0;
  logic [2:0]  reg_idx = '0;
  logic [15:0] pc = '0;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, ea, operand;
  logic [15:0] mem_rdata = '0;
  logic        rf_we, mem_re, done, illegal;
  logic [15:0] rf [8];
  logic [15:0] mrf [8];
  int checks = 0;
  int fails = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  ea_unit uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .addr_field(addr_field),
    .reg_idx(reg_idx), .pc(pc), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .illegal(illegal),
    .ea(ea), .operand(operand)
  );

  function automatic logic [15:0] memval(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] init_reg(input int i);
    case (i)
      1: return 16'h1111;
      2: return 16'hBEEF;
      3: return 16'h0420;
      4: return 16'hFFF0;
      5: return 16'hFFFF;
      6: return 16'h0100;
      7: return 16'h7777;
      default: return 16'h0000;
    endcase
  endfunction

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) rf[i] <= init_reg(i);
    end else if (rf_we) begin
      rf[rf_waddr] <= rf_wdata;
    end
    if (mem_re) mem_rdata <= memval(mem_addr);
  end

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [3:0] m,
                        input logic [15:0] a, input logic [2:0] idx,
                        input logic [15:0] pcv, input bit poke);
    logic [15:0] r, exp_ea, exp_op, exp_wb;
    int n, lat, seen;
    bit bad, wb;
    r = mrf[idx]; bad = 0; wb = 0; n = 1; exp_wb = r + 16'd1;
    case (m)
      4'd0: begin n = 0; exp_ea = 16'h0; exp_op = a; end
      4'd1: exp_ea = a;
      4'd2: begin n = 2; exp_ea = memval(a); end
      4'd3: begin n = 0; exp_ea = 16'h0; exp_op = r; end
      4'd4: exp_ea = r;
      4'd5: exp_ea = a + r;
      4'd6: exp_ea = a + pcv;
      4'd7: begin exp_ea = a + r + 16'd1; wb = 1; end
      4'd8: begin exp_ea = a + r; wb = 1; end
      default: begin bad = 1; n = 0; exp_ea = 16'h0; exp_op = 16'h0; end
    endcase
    if (n > 0) exp_op = memval(exp_ea);
    lat = 1 + 2 * n;
    @(negedge clk);
    start = 1'b1; mode = m; addr_field = a; reg_idx = idx; pc = pcv;
    @(negedge clk);
    start = 1'b0; mode = 4'd0; addr_field = 16'hDEAD; reg_idx = 3'd7; pc = 16'h0;
    seen = 0;
    for (int k = 1; k <= lat + 3; k++) begin
      @(negedge clk);
      if (mem_re) seen++;
      if (poke && k == 1) start = 1'b1;
      if (poke && k == lat - 1) start = 1'b0;
      if (k < lat) begin
        chk({tag, "/R8"}, "done early", {15'b0, done}, 16'h0);
      end else if (k == lat) begin
        chk({tag, "/R8"}, "done", {15'b0, done}, 16'h1);
        chk(tag, "ea", ea, exp_ea);
        chk(tag, "operand", operand, exp_op);
        chk({tag, "/R7"}, "illegal", {15'b0, illegal}, {15'b0, bad});
        chk(tag, "reads", 16'(seen), 16'(n));
        chk({tag, "/R6"}, "rf_we", {15'b0, rf_we}, {15'b0, wb});
        if (wb) begin
          chk({tag, "/R6"}, "wb idx", {13'b0, rf_waddr}, {13'b0, idx});
          chk({tag, "/R6"}, "wb val", rf_wdata, exp_wb);
        end
      end else begin
        chk({tag, "/R8"}, "done after pulse", {15'b0, done}, 16'h0);
        chk({tag, "/R9"}, "stray read", {15'b0, mem_re}, 16'h0);
      end
    end
    if (wb) mrf[idx] = exp_wb;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mrf[i] = init_reg(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset", "done", {15'b0, done}, 16'h0);
    chk("R8 reset", "mem_re", {15'b0, mem_re}, 16'h0);
    chk("R6 reset", "rf_we", {15'b0, rf_we}, 16'h0);
    run_op("R1 imm",      4'd0, 16'h1234, 3'd1, 16'h0000, 0);
    run_op("R2 direct",   4'd1, 16'h0040, 3'd0, 16'h0000, 0);
    run_op("R3 indirect", 4'd2, 16'h0300, 3'd0, 16'h0000, 0);
    run_op("R9 indirect busy", 4'd2, 16'h8001, 3'd0, 16'h0000, 1);
    run_op("R9 direct busy",   4'd1, 16'hABCD, 3'd0, 16'h0000, 1);
    run_op("R4 register", 4'd3, 16'h0000, 3'd2, 16'h0000, 0);
    run_op("R4 reg indirect", 4'd4, 16'h0000, 3'd3, 16'h0000, 0);
    run_op("R5 disp wrap",    4'd5, 16'h0020, 3'd4, 16'h0000, 0);
    run_op("R5 rel wrap",     4'd6, 16'h0200, 3'd0, 16'hFF00, 0);
    run_op("R6 pre wrap",     4'd7, 16'h0010, 3'd5, 16'h0000, 0);
    run_op("R6 pre readback", 4'd3, 16'h0000, 3'd5, 16'h0000, 0);
    run_op("R6 post",         4'd8, 16'h0008, 3'd6, 16'h0000, 0);
    run_op("R6 post again",   4'd8, 16'h0008, 3'd6, 16'h0000, 0);
    run_op("R6 post readback", 4'd3, 16'h0000, 3'd6, 16'h0000, 0);
    run_op("R7 code9",  4'd9,  16'h5555, 3'd7, 16'h0000, 0);
    run_op("R7 code15", 4'd15, 16'h5555, 3'd7, 16'h0000, 0);
    run_op("R7 after bad, reg7 intact", 4'd3, 16'h0000, 3'd7, 16'h0000, 0);
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule